// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block lets a host reach the 16-bit internal control registers of a PHY through a narrow side port. The host hands over one command at a time on a valid/ready command channel: capture an address, write a data value to the captured address, or read the captured address. The block drives a 16-bit data bus toward the PHY and four strobes: address capture, data capture, write and read. It paces each strobe with a four-phase handshake against one acknowledge input from the PHY.

Each command ends with a single beat on a valid/ready response channel. The beat carries the read data and a timeout flag. A command is accepted only when `cmd_valid` and `cmd_ready` are both high on a clock edge. `cmd_ready` stays low from acceptance until the response beat has been taken. The response beat holds `rsp_valid`, `rsp_data` and `rsp_timeout` unchanged for as long as `rsp_ready` is low.

Every acknowledge wait is bounded by a cycle counter, so a dead PHY cannot hang the host. A write that puts the PHY into reset is a special case: a PHY in reset cannot acknowledge, so that write fires its strobe without waiting.

Top module: `phy_cr_master`

## Requirements
- R1: After reset, all four strobes are low, `cmd_ready` is high, `rsp_valid` is low and `busy` is low.
- R2: An address command (`cmd_op` = 0) drives the address on `phy_din` before `phy_cap_addr` rises. The strobe stays high until `phy_ack` is seen high and then drops. The command completes once `phy_ack` is seen low.
- R3: A write command (`cmd_op` = 1) drives the value on `phy_din`, runs a full handshake on `phy_cap_data`, and then runs a full handshake on `phy_wr`.
- R4: A read command (`cmd_op` = 2) raises `phy_rd` and samples `phy_dout` in the cycle `phy_ack` is first seen high, while `phy_rd` is still high. That sample is returned on `rsp_data`. Address, write and no-op commands return 0.
- R5: When the held address equals `RST_ADDR` (default 0x7F3F) and bit `RST_BIT` (default 0) of the write value is set, `phy_wr` is high for exactly one cycle after the data-capture handshake. The response then follows with no acknowledge wait and `rsp_timeout` = 0.
- R6: If `phy_ack` does not reach the expected level within `TMO_CYCLES` cycles of a handshake phase, all strobes drop and the response carries `rsp_timeout` = 1.
- R7: At most one strobe is high in any cycle, and no strobe is high while `cmd_ready` is high.
- R8: `cmd_ready` is low and `busy` is high from acceptance until the response is taken. A command offered in that window starts no strobe.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_timeout` hold.
- R10: Op code 3 is a no-op. It raises no strobe and returns a response with data 0 and `rsp_timeout` = 0.
- R11: The held address changes only when an address command completes without timeout. The reset check in R5 uses this held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 no-op |
| cmd_data | input | DW | Address or write value |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | DW | Read data, 0 for other commands |
| rsp_timeout | output | 1 | An acknowledge wait expired |
| busy | output | 1 | A command is in flight |
| phy_din | output | DW | Data bus toward the PHY |
| phy_cap_addr | output | 1 | Address capture strobe |
| phy_cap_data | output | 1 | Data capture strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | DW | Read data from the PHY, valid while read is acknowledged |

## Verification
The bench drives a PHY model whose read data is only meaningful while `phy_rd` is high. A design that sampled after dropping the strobe would return the idle pattern. It counts the cycles `phy_wr` spends high, so that a reset write which still waited for acknowledge shows more than one cycle, and a normal write wrongly treated as a reset shows exactly one. Timeouts are forced in both the rise and the fall phase, and a timed-out address capture is followed by a reset write, which exposes a held address that was updated without a completed handshake. Commands offered during a stalled response would show up as extra strobe edges, and data changing under back-pressure would show up as a stability miss.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NOP   = 2'd3
  } cr_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CAPD, S_WR, S_RD, S_FIRE, S_RSP
  } seq_st_e;

  typedef enum logic [1:0] {
    H_IDLE, H_RISE, H_FALL
  } hs_st_e;
endpackage

// File: rtl/phy_cr_tmo.sv
module phy_cr_tmo #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= CW'(LIMIT - 1);
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = run && !load && (cnt == '0);

  assert_tmo_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/phy_cr_hshake.sv
module phy_cr_hshake
  import phy_cr_pkg::*;
#(
  parameter int TMO_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic ack_hi,
  output logic done,
  output logic tmo
);
  hs_st_e st;
  logic   t_load, t_run, t_exp;

  assign t_load = start || (st == H_RISE && ack);
  assign t_run  = (st != H_IDLE);

  phy_cr_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(t_load), .run(t_run), .expired(t_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) st <= H_IDLE;
    else begin
      case (st)
        H_IDLE: if (start) st <= H_RISE;
        H_RISE: if (ack) st <= H_FALL; else if (t_exp) st <= H_IDLE;
        H_FALL: if (!ack || t_exp) st <= H_IDLE;
        default: st <= H_IDLE;
      endcase
    end
  end

  assign req    = (st == H_RISE);
  assign ack_hi = (st == H_RISE) && ack;
  assign done   = (st == H_FALL) && !ack;
  assign tmo    = t_exp && (((st == H_RISE) && !ack) || ((st == H_FALL) && ack));

  // strobe only drops after acknowledge or on expiry
  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> ($past(ack) || $past(t_exp)));
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int          DW         = 16,
  parameter int          TMO_CYCLES = 1024,
  parameter logic [15:0] RST_ADDR   = 16'h7F3F,
  parameter int          RST_BIT    = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_timeout,
  output logic          busy,
  output logic [DW-1:0] phy_din,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr,
  output logic          phy_rd,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout
);
  seq_st_e       st;
  logic [DW-1:0] din_q, addr_q, rd_q;
  logic          tmo_q, start_q;
  logic          hs_req, hs_ack_hi, hs_done, hs_tmo;
  logic          rst_write;

  phy_cr_hshake #(.TMO_CYCLES(TMO_CYCLES)) u_hs (
    .clk(clk), .rst_n(rst_n), .start(start_q), .ack(phy_ack),
    .req(hs_req), .ack_hi(hs_ack_hi), .done(hs_done), .tmo(hs_tmo)
  );

  assign rst_write = (addr_q == DW'(RST_ADDR)) && din_q[RST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      din_q   <= '0;
      addr_q  <= '0;
      rd_q    <= '0;
      tmo_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          rd_q  <= '0;
          tmo_q <= 1'b0;
          case (cr_op_e'(cmd_op))
            OP_ADDR:  begin din_q <= cmd_data; st <= S_ADDR; start_q <= 1'b1; end
            OP_WRITE: begin din_q <= cmd_data; st <= S_CAPD; start_q <= 1'b1; end
            OP_READ:  begin st <= S_RD; start_q <= 1'b1; end
            default:  st <= S_RSP;
          endcase
        end
        S_ADDR: begin
          if (hs_done) begin addr_q <= din_q; st <= S_RSP; end
          else if (hs_tmo) begin tmo_q <= 1'b1; st <= S_RSP; end
        end
        S_CAPD: begin
          if (hs_done) begin
            if (rst_write) st <= S_FIRE;
            else begin st <= S_WR; start_q <= 1'b1; end
          end else if (hs_tmo) begin tmo_q <= 1'b1; st <= S_RSP; end
        end
        S_WR: begin
          if (hs_done) st <= S_RSP;
          else if (hs_tmo) begin tmo_q <= 1'b1; st <= S_RSP; end
        end
        S_RD: begin
          if (hs_ack_hi) rd_q <= phy_dout;
          if (hs_done) st <= S_RSP;
          else if (hs_tmo) begin tmo_q <= 1'b1; st <= S_RSP; end
        end
        S_FIRE: st <= S_RSP;
        S_RSP:  if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (st == S_IDLE);
  assign busy         = (st != S_IDLE);
  assign rsp_valid    = (st == S_RSP);
  assign rsp_data     = rd_q;
  assign rsp_timeout  = tmo_q;
  assign phy_din      = din_q;
  assign phy_cap_addr = hs_req && (st == S_ADDR);
  assign phy_cap_data = hs_req && (st == S_CAPD);
  assign phy_wr       = (hs_req && (st == S_WR)) || (st == S_FIRE);
  assign phy_rd       = hs_req && (st == S_RD);

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !(phy_cap_addr || phy_cap_data || phy_wr || phy_rd));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_timeout)));
  assert_din_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cap_addr || phy_cap_data || phy_wr) |=> ($stable(phy_din) || !(phy_cap_addr || phy_cap_data || phy_wr)));
endmodule

// File: tb/phy_cr_master_test.sv
module phy_cr_master_test;
  localparam int DW = 16;
  localparam int TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [DW-1:0] cmd_data = '0;
  logic cmd_ready, rsp_valid, rsp_timeout, busy;
  logic [DW-1:0] rsp_data, phy_din, phy_dout;
  logic phy_cap_addr, phy_cap_data, phy_wr, phy_rd, phy_ack;

  always #10 clk = ~clk;

  phy_cr_master #(.DW(DW), .TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
    .busy(busy), .phy_din(phy_din), .phy_cap_addr(phy_cap_addr),
    .phy_cap_data(phy_cap_data), .phy_wr(phy_wr), .phy_rd(phy_rd),
    .phy_ack(phy_ack), .phy_dout(phy_dout)
  );

  // PHY model: ack follows any strobe after three cycles
  logic ack_en = 1'b1, ack_stuck = 1'b0;
  logic [2:0] dly = '0;
  logic [DW-1:0] m_addr = '0, m_cdata = '0;
  logic p_ca = 1'b0, p_cd = 1'b0, p_wr = 1'b0, p_rd = 1'b0;
  int n_ca = 0, n_cd = 0, n_wr = 0, n_rd = 0, wr_cyc = 0, bad_oh = 0;
  logic any_stb;
  assign any_stb = phy_cap_addr | phy_cap_data | phy_wr | phy_rd;
  assign phy_ack = ack_stuck | (ack_en & dly[2]);
  assign phy_dout = phy_rd ? (m_addr ^ 16'h5A5A) : 16'hDEAD;

  always @(posedge clk) begin
    dly <= {dly[1:0], any_stb};
    p_ca <= phy_cap_addr; p_cd <= phy_cap_data; p_wr <= phy_wr; p_rd <= phy_rd;
    if (phy_cap_addr && !p_ca) begin n_ca <= n_ca + 1; m_addr <= phy_din; end
    if (phy_cap_data && !p_cd) begin n_cd <= n_cd + 1; m_cdata <= phy_din; end
    if (phy_wr && !p_wr) n_wr <= n_wr + 1;
    if (phy_rd && !p_rd) n_rd <= n_rd + 1;
    if (phy_wr) wr_cyc <= wr_cyc + 1;
    if (rst_n && ((32'(phy_cap_addr) + 32'(phy_cap_data) + 32'(phy_wr) + 32'(phy_rd) > 1)
                  || (cmd_ready && any_stb))) bad_oh <= bad_oh + 1;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [DW-1:0] d, input int hold,
                         output logic [DW-1:0] rd, output logic to);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready && busy, "R8 busy after accept", {cmd_ready, busy}, 2'b01);
    while (!rsp_valid) @(negedge clk);
    if (hold > 0) begin
      logic [DW-1:0] d0;
      int ca0, cd0, wr0, rd0;
      d0 = rsp_data;
      ca0 = n_ca; cd0 = n_cd; wr0 = n_wr; rd0 = n_rd;
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 16'h0BAD;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == d0, "R9 response held", rsp_data, d0);
        chk(!cmd_ready, "R8 no accept while busy", cmd_ready, 0);
      end
      cmd_valid = 1'b0;
      chk(n_ca == ca0 && n_cd == cd0 && n_wr == wr0 && n_rd == rd0,
          "R8 no strobe from blocked command", n_ca + n_cd + n_wr + n_rd, ca0 + cd0 + wr0 + rd0);
    end
    rd = rsp_data; to = rsp_timeout;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // op, data, expected rsp_data, expected timeout
  localparam logic [34:0] VEC [0:8] = '{
    {2'd0, 16'h0010, 16'h0000, 1'b0},
    {2'd1, 16'h1234, 16'h0000, 1'b0},
    {2'd2, 16'h0000, 16'h5A4A, 1'b0},
    {2'd0, 16'h7F3F, 16'h0000, 1'b0},
    {2'd2, 16'h0000, 16'h2565, 1'b0},
    {2'd0, 16'h2003, 16'h0000, 1'b0},
    {2'd1, 16'hBEEF, 16'h0000, 1'b0},
    {2'd2, 16'h0000, 16'h7A59, 1'b0},
    {2'd3, 16'hFFFF, 16'h0000, 1'b0}
  };

  initial begin
    logic [DW-1:0] rd;
    logic to;
    int s_ca, s_cd, s_wr, s_rd, s_cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!any_stb && cmd_ready && !rsp_valid && !busy, "R1 reset outputs",
        {any_stb, cmd_ready, rsp_valid, busy}, 4'b0100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!any_stb && cmd_ready && !rsp_valid, "R1 after release", {any_stb, cmd_ready, rsp_valid}, 3'b010);

    for (int v = 0; v < 9; v++) begin
      logic [1:0] op;
      logic [DW-1:0] d, e;
      op = VEC[v][34:33]; d = VEC[v][32:17]; e = VEC[v][16:1];
      s_ca = n_ca; s_cd = n_cd; s_wr = n_wr; s_rd = n_rd; s_cyc = wr_cyc;
      run_cmd(op, d, 0, rd, to);
      chk(rd == e && to == VEC[v][0], "R4 response data", {rd, to}, {e, VEC[v][0]});
      case (op)
        2'd0: chk(n_ca == s_ca + 1 && m_addr == d, "R2 address captured", m_addr, d);
        2'd1: begin
          chk(n_cd == s_cd + 1 && m_cdata == d, "R3 data captured", m_cdata, d);
          chk(n_wr == s_wr + 1 && wr_cyc - s_cyc > 1, "R3 write handshake", wr_cyc - s_cyc, 2);
        end
        2'd2: chk(n_rd == s_rd + 1, "R4 one read strobe", n_rd - s_rd, 1);
        default: chk(n_ca == s_ca && n_cd == s_cd && n_wr == s_wr && n_rd == s_rd,
                     "R10 no-op quiet", n_ca + n_cd + n_wr + n_rd, s_ca + s_cd + s_wr + s_rd);
      endcase
    end

    // R5 reset write fires once without waiting
    run_cmd(2'd0, 16'h7F3F, 0, rd, to);
    s_cyc = wr_cyc; s_wr = n_wr;
    run_cmd(2'd1, 16'h0001, 0, rd, to);
    chk(wr_cyc - s_cyc == 1 && n_wr == s_wr + 1, "R5 write strobe one cycle", wr_cyc - s_cyc, 1);
    chk(to == 1'b0, "R5 no timeout", to, 0);

    // R11 timed-out address keeps old held address
    ack_en = 1'b0;
    run_cmd(2'd0, 16'h0001, 0, rd, to);
    chk(to == 1'b1, "R6 rise timeout on address", to, 1);
    chk(!any_stb, "R6 strobes dropped", any_stb, 0);
    ack_en = 1'b1;
    s_cyc = wr_cyc;
    run_cmd(2'd1, 16'h0001, 0, rd, to);
    chk(wr_cyc - s_cyc == 1, "R11 held address survives timeout", wr_cyc - s_cyc, 1);
    run_cmd(2'd0, 16'h0055, 0, rd, to);
    s_cyc = wr_cyc;
    run_cmd(2'd1, 16'h0001, 0, rd, to);
    chk(wr_cyc - s_cyc > 1 && to == 1'b0, "R11 other address writes normally", wr_cyc - s_cyc, 2);

    // R6 fall-phase timeout with ack stuck high
    ack_stuck = 1'b1;
    run_cmd(2'd2, 16'h0000, 0, rd, to);
    chk(to == 1'b1, "R6 fall timeout on read", to, 1);
    ack_stuck = 1'b0;
    repeat (6) @(negedge clk);

    // R9 / R8 back-pressure with a read of 0x0055
    run_cmd(2'd2, 16'h0000, 5, rd, to);
    chk(rd == (16'h0055 ^ 16'h5A5A) && to == 1'b0, "R4 read after stall", rd, 16'h0055 ^ 16'h5A5A);

    chk(bad_oh == 0, "R7 strobe exclusivity", bad_oh, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule